// File: doc/BRIEF.md
# Modified-Immediate Data-Processing Decoder

This block takes one 32-bit instruction word from the wide, two-halfword encoding of a compact instruction set. If that word belongs to the data-processing class with a modified immediate operand, the block turns it into control fields for an execute unit. The fields are an operation code in the execute unit's own 4-bit space, the destination and source register numbers, the flag-update bit, a register write enable, an indication that operand A is forced to zero, and a stack-pointer-update marker. The block also passes out the raw 12-bit immediate field so that a separate expander can build the constant from it.

Register numbers in the word can turn one operation into another. A source register of 15 makes the two OR forms into move forms. A destination of 15 with the flag bit set makes four arithmetic or logic forms into compares that write no register. Unused opcodes are flagged as illegal. So is any other use of destination 15.

All outputs are registered, and each result appears one clock after the word is presented.

Top module: `t2_immdp_decoder`

## Requirements
- R1: `out_valid` equals `in_valid` from one clock earlier. Every output is registered, and reset clears all outputs to zero.
- R2: A word is in the class (`out_hit`=1) when bits [31:27]=5'b11110, bit 25=0 and bit 15=0. Outside the class, `out_op`, `out_wr_en`, `out_illegal`, `out_zero_a` and `out_sp_upd` are all 0.
- R3: `out_s` is bit 20, `out_rn` is bits [19:16] and `out_rd` is bits [11:8] of the word.
- R4: `out_imm12` is {bit 26, bits [14:12], bits [7:0]}.
- R5: Input opcode bits [24:21] map to output codes as follows: 0 AND→0, 1 BIC→1, 2 ORR→2, 3 ORN→3, 4 EOR→4, 8 ADD→8, 10 ADC→10, 11 SBC→11, 13 SUB→13, 14 RSB→14.
- R6: Input opcodes 5, 6, 7, 9, 12 and 15 set `out_illegal`=1 and force `out_op`=0 and `out_wr_en`=0.
- R7: ORR with Rn=15 gives MOV (code 5), and ORN with Rn=15 gives MVN (code 6). Both set `out_zero_a`=1. For every other operation `out_zero_a`=0.
- R8: With S=1 and Rd=15, AND gives TST (7), EOR gives TEQ (9), ADD gives CMN (12) and SUB gives CMP (15). Each has `out_wr_en`=0 and `out_illegal`=0.
- R9: Rd=15 in any in-class word not covered by R8 sets `out_illegal`=1, with `out_op`=0 and `out_wr_en`=0.
- R10: `out_wr_en`=1 exactly when the word is in class, legal and not a compare.
- R11: `out_sp_upd`=1 exactly for legal ADD or SUB with Rd=13 and Rn=13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Instruction word present |
| in_word | input | 32 | Instruction word |
| out_valid | output | 1 | Registered copy of in_valid |
| out_hit | output | 1 | Word is in the modified-immediate class |
| out_op | output | 4 | Execute-unit operation code |
| out_rd | output | 4 | Destination register |
| out_rn | output | 4 | Source register |
| out_s | output | 1 | Flag-update bit |
| out_wr_en | output | 1 | Destination register write enable |
| out_illegal | output | 1 | Undefined encoding |
| out_zero_a | output | 1 | Operand A is forced to zero |
| out_sp_upd | output | 1 | Stack-pointer update by ADD/SUB |
| out_imm12 | output | 12 | Raw immediate field for the expander |

## Verification
Every decoded field, including the alias, illegal and stack-pointer flags, comes from a single register stage. Each result is therefore due on the first rising edge after the word is driven. The bench drives each word on a falling edge and waits for the next rising edge. It then samples one nanosecond later, so every check reads the value produced by exactly that edge. The in-design properties relate the word seen at one edge to the outputs at the following edge in the same way.

// File: rtl/t2dec_pkg.sv
package t2dec_pkg;
    localparam int INSN_W = 32;
    localparam int REG_W  = 4;
    localparam int OP_W   = 4;
    localparam int IMM_W  = 1 + 3 + 8;
    localparam logic [REG_W-1:0] REG_PC = REG_W'(15);
    localparam logic [REG_W-1:0] REG_SP = REG_W'(13);

    typedef enum logic [OP_W-1:0] {
        XOP_AND = 4'd0,  XOP_BIC = 4'd1,  XOP_ORR = 4'd2,  XOP_ORN = 4'd3,
        XOP_EOR = 4'd4,  XOP_MOV = 4'd5,  XOP_MVN = 4'd6,  XOP_TST = 4'd7,
        XOP_ADD = 4'd8,  XOP_TEQ = 4'd9,  XOP_ADC = 4'd10, XOP_SBC = 4'd11,
        XOP_CMN = 4'd12, XOP_SUB = 4'd13, XOP_RSB = 4'd14, XOP_CMP = 4'd15
    } xop_e;

    typedef struct packed {
        logic             valid;
        logic             hit;
        xop_e             op;
        logic [REG_W-1:0] rd;
        logic [REG_W-1:0] rn;
        logic             s;
        logic             wr_en;
        logic             illegal;
        logic             zero_a;
        logic             sp_upd;
        logic [IMM_W-1:0] imm12;
    } dec_out_t;
endpackage

// File: rtl/t2dec_fields.sv
module t2dec_fields
    import t2dec_pkg::*;
(
    input  logic [INSN_W-1:0] word,
    output logic              hit,
    output logic [3:0]        opc,
    output logic              s,
    output logic [REG_W-1:0]  rn,
    output logic [REG_W-1:0]  rd,
    output logic [IMM_W-1:0]  imm12
);
    always_comb begin
        hit   = (word[31:27] == 5'b11110) && !word[25] && !word[15];
        opc   = word[24:21];
        s     = word[20];
        rn    = word[19:16];
        rd    = word[11:8];
        imm12 = {word[26], word[14:12], word[7:0]};
    end
endmodule

// File: rtl/t2dec_opmap.sv
module t2dec_opmap
    import t2dec_pkg::*;
(
    input  logic [3:0]       opc,
    input  logic             s,
    input  logic [REG_W-1:0] rn,
    input  logic [REG_W-1:0] rd,
    output xop_e             op,
    output logic             is_cmp,
    output logic             zero_a,
    output logic             bad,
    output logic             addsub
);
    logic cmp_form;
    logic rn_pc;

    always_comb begin
        cmp_form = s && (rd == REG_PC);
        rn_pc    = (rn == REG_PC);
        op       = XOP_AND;
        is_cmp   = 1'b0;
        zero_a   = 1'b0;
        bad      = 1'b0;
        addsub   = 1'b0;
        unique case (opc)
            4'd0:  begin op = cmp_form ? XOP_TST : XOP_AND; is_cmp = cmp_form; end
            4'd1:  op = XOP_BIC;
            4'd2:  begin op = rn_pc ? XOP_MOV : XOP_ORR; zero_a = rn_pc; end
            4'd3:  begin op = rn_pc ? XOP_MVN : XOP_ORN; zero_a = rn_pc; end
            4'd4:  begin op = cmp_form ? XOP_TEQ : XOP_EOR; is_cmp = cmp_form; end
            4'd8:  begin op = cmp_form ? XOP_CMN : XOP_ADD; is_cmp = cmp_form; addsub = 1'b1; end
            4'd10: op = XOP_ADC;
            4'd11: op = XOP_SBC;
            4'd13: begin op = cmp_form ? XOP_CMP : XOP_SUB; is_cmp = cmp_form; addsub = 1'b1; end
            4'd14: op = XOP_RSB;
            default: bad = 1'b1;
        endcase
    end
endmodule

// File: rtl/t2_immdp_decoder.sv
module t2_immdp_decoder
    import t2dec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [INSN_W-1:0] in_word,
    output logic              out_valid,
    output logic              out_hit,
    output logic [OP_W-1:0]   out_op,
    output logic [REG_W-1:0]  out_rd,
    output logic [REG_W-1:0]  out_rn,
    output logic              out_s,
    output logic              out_wr_en,
    output logic              out_illegal,
    output logic              out_zero_a,
    output logic              out_sp_upd,
    output logic [IMM_W-1:0]  out_imm12
);
    logic             f_hit, f_s;
    logic [3:0]       f_opc;
    logic [REG_W-1:0] f_rn, f_rd;
    logic [IMM_W-1:0] f_imm;
    xop_e             m_op;
    logic             m_cmp, m_zero, m_bad, m_addsub;
    dec_out_t         dec_d, dec_q;

    t2dec_fields u_fields (
        .word(in_word), .hit(f_hit), .opc(f_opc), .s(f_s),
        .rn(f_rn), .rd(f_rd), .imm12(f_imm)
    );

    t2dec_opmap u_opmap (
        .opc(f_opc), .s(f_s), .rn(f_rn), .rd(f_rd), .op(m_op),
        .is_cmp(m_cmp), .zero_a(m_zero), .bad(m_bad), .addsub(m_addsub)
    );

    always_comb begin
        logic illegal;
        illegal       = m_bad || ((f_rd == REG_PC) && !m_cmp);
        dec_d         = '0;
        dec_d.valid   = in_valid;
        dec_d.hit     = f_hit;
        dec_d.rd      = f_rd;
        dec_d.rn      = f_rn;
        dec_d.s       = f_s;
        dec_d.imm12   = f_imm;
        dec_d.op      = XOP_AND;
        if (f_hit) begin
            dec_d.illegal = illegal;
            if (!illegal) begin
                dec_d.op     = m_op;
                dec_d.wr_en  = !m_cmp;
                dec_d.zero_a = m_zero;
                dec_d.sp_upd = m_addsub && (f_rd == REG_SP) && (f_rn == REG_SP);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dec_q <= '0;
        else        dec_q <= dec_d;
    end

    assign out_valid   = dec_q.valid;
    assign out_hit     = dec_q.hit;
    assign out_op      = dec_q.op;
    assign out_rd      = dec_q.rd;
    assign out_rn      = dec_q.rn;
    assign out_s       = dec_q.s;
    assign out_wr_en   = dec_q.wr_en;
    assign out_illegal = dec_q.illegal;
    assign out_zero_a  = dec_q.zero_a;
    assign out_sp_upd  = dec_q.sp_upd;
    assign out_imm12   = dec_q.imm12;

    a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r2_outside_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (in_word[31:27] != 5'b11110) |=> (!out_wr_en && !out_illegal && out_op == 4'd0));
    a_r4_imm_field: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> out_imm12 == {$past(in_word[26]), $past(in_word[14:12]), $past(in_word[7:0])});
    a_r8_tst_alias: assert property (@(posedge clk) disable iff (!rst_n)
        (in_word[31:27] == 5'b11110 && !in_word[25] && !in_word[15] &&
         in_word[24:21] == 4'd0 && in_word[20] && in_word[11:8] == 4'd15)
        |=> (out_op == 4'd7 && !out_wr_en && !out_illegal));
    a_r9_illegal_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        out_illegal |-> (!out_wr_en && !out_sp_upd && !out_zero_a));
    a_r7_mov_alias: assert property (@(posedge clk) disable iff (!rst_n)
        (in_word[31:27] == 5'b11110 && !in_word[25] && !in_word[15] &&
         in_word[24:21] == 4'd2 && in_word[19:16] == 4'd15 && in_word[11:8] != 4'd15)
        |=> (out_op == 4'd5 && out_zero_a && out_wr_en));
endmodule

// File: tb/t2_immdp_decoder_tb.sv
module t2_immdp_decoder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic        out_valid, out_hit, out_s, out_wr_en, out_illegal, out_zero_a, out_sp_upd;
    logic [3:0]  out_op, out_rd, out_rn;
    logic [11:0] out_imm12;
    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    t2_immdp_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .out_valid(out_valid), .out_hit(out_hit), .out_op(out_op), .out_rd(out_rd),
        .out_rn(out_rn), .out_s(out_s), .out_wr_en(out_wr_en), .out_illegal(out_illegal),
        .out_zero_a(out_zero_a), .out_sp_upd(out_sp_upd), .out_imm12(out_imm12)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [3:0] opc, input logic s,
                                       input logic [3:0] rn, input logic [3:0] rd,
                                       input logic i, input logic [2:0] i3, input logic [7:0] i8);
        return {5'b11110, i, 1'b0, opc, s, rn, 1'b0, i3, rd, i8};
    endfunction

    task automatic drive(input logic [31:0] w);
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = w;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset;
        chk("R1 reset valid", out_valid, 0);
        chk("R1 reset op", out_op, 0);
        chk("R1 reset wr_en", out_wr_en, 0);
        chk("R1 reset imm", out_imm12, 0);
    endtask

    task automatic t_basic;
        int codes[10] = '{0, 1, 2, 3, 4, 8, 10, 11, 13, 14};
        foreach (codes[k]) begin
            drive(mk(codes[k][3:0], 1'b0, 4'd4, 4'd3, 1'b0, 3'd0, 8'h11));
            chk("R5 op", out_op, codes[k]);
            chk("R10 wr_en", out_wr_en, 1);
            chk("R2 hit", out_hit, 1);
        end
        drive(mk(4'd8, 1'b1, 4'd9, 4'd2, 1'b0, 3'd0, 8'h00));
        chk("R3 s", out_s, 1);
        chk("R3 rn", out_rn, 9);
        chk("R3 rd", out_rd, 2);
        chk("R1 valid", out_valid, 1);
        chk("R11 no sp", out_sp_upd, 0);
    endtask

    task automatic t_illegal_ops;
        int codes[6] = '{5, 6, 7, 9, 12, 15};
        foreach (codes[k]) begin
            drive(mk(codes[k][3:0], 1'b1, 4'd1, 4'd1, 1'b0, 3'd0, 8'h00));
            chk("R6 illegal", out_illegal, 1);
            chk("R6 op", out_op, 0);
            chk("R6 wr_en", out_wr_en, 0);
        end
    endtask

    task automatic t_mov;
        drive(mk(4'd2, 1'b0, 4'd15, 4'd6, 1'b0, 3'd0, 8'h00));
        chk("R7 mov", out_op, 5);
        chk("R7 zero_a", out_zero_a, 1);
        drive(mk(4'd3, 1'b1, 4'd15, 4'd6, 1'b0, 3'd0, 8'h00));
        chk("R7 mvn", out_op, 6);
        chk("R7 zero_a mvn", out_zero_a, 1);
        drive(mk(4'd2, 1'b0, 4'd14, 4'd6, 1'b0, 3'd0, 8'h00));
        chk("R7 orr kept", out_op, 2);
        chk("R7 zero_a off", out_zero_a, 0);
    endtask

    task automatic t_cmp;
        int src[4] = '{0, 4, 8, 13};
        int dst[4] = '{7, 9, 12, 15};
        foreach (src[k]) begin
            drive(mk(src[k][3:0], 1'b1, 4'd5, 4'd15, 1'b0, 3'd0, 8'h00));
            chk("R8 cmp op", out_op, dst[k]);
            chk("R8 no write", out_wr_en, 0);
            chk("R8 legal", out_illegal, 0);
        end
    endtask

    task automatic t_rd15;
        drive(mk(4'd0, 1'b0, 4'd5, 4'd15, 1'b0, 3'd0, 8'h00));
        chk("R9 and S0 rd15", out_illegal, 1);
        drive(mk(4'd1, 1'b1, 4'd5, 4'd15, 1'b0, 3'd0, 8'h00));
        chk("R9 bic rd15", out_illegal, 1);
        chk("R9 wr_en", out_wr_en, 0);
        drive(mk(4'd2, 1'b0, 4'd15, 4'd15, 1'b0, 3'd0, 8'h00));
        chk("R9 mov rd15", out_illegal, 1);
    endtask

    task automatic t_sp;
        drive(mk(4'd8, 1'b0, 4'd13, 4'd13, 1'b0, 3'd0, 8'h04));
        chk("R11 add sp", out_sp_upd, 1);
        drive(mk(4'd13, 1'b1, 4'd13, 4'd13, 1'b0, 3'd0, 8'h04));
        chk("R11 sub sp", out_sp_upd, 1);
        drive(mk(4'd14, 1'b0, 4'd13, 4'd13, 1'b0, 3'd0, 8'h04));
        chk("R11 rsb no sp", out_sp_upd, 0);
        drive(mk(4'd8, 1'b0, 4'd12, 4'd13, 1'b0, 3'd0, 8'h04));
        chk("R11 rn12 no sp", out_sp_upd, 0);
    endtask

    task automatic t_imm;
        drive(mk(4'd0, 1'b0, 4'd1, 4'd2, 1'b1, 3'b101, 8'h3c));
        chk("R4 imm", out_imm12, 12'hd3c);
        drive(mk(4'd0, 1'b0, 4'd1, 4'd2, 1'b0, 3'b010, 8'hff));
        chk("R4 imm2", out_imm12, 12'h2ff);
    endtask

    task automatic t_outside;
        drive(32'hE000_0000);
        chk("R2 hit off", out_hit, 0);
        chk("R2 wr_en off", out_wr_en, 0);
        drive(mk(4'd0, 1'b0, 4'd1, 4'd2, 1'b0, 3'd0, 8'h00) | 32'h0200_0000);
        chk("R2 bit25", out_hit, 0);
        chk("R2 bit25 illegal", out_illegal, 0);
        drive(mk(4'd5, 1'b0, 4'd1, 4'd2, 1'b0, 3'd0, 8'h00) | 32'h0000_8000);
        chk("R2 bit15", out_hit, 0);
        chk("R2 bit15 illegal", out_illegal, 0);
        @(negedge clk);
        in_valid = 1'b0;
        @(posedge clk);
        #1;
        chk("R1 valid drop", out_valid, 0);
    endtask

    initial begin
        #50000;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #9;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_basic();
        t_illegal_ops();
        t_mov();
        t_cmp();
        t_rd15();
        t_sp();
        t_imm();
        t_outside();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule